// File: doc/BRIEF.md
# Compressed Byte Stream Parser with Data History

This block sits at the front of a dictionary-style decompressor. It takes the compressed stream one byte per cycle over a valid/ready handshake. Each byte is classed as header, control or data. The eight header bytes give the size of the decoded output and say whether the block is compressed at all. After the header, the stream is a run of groups. Each group opens with a control word, and each bit of that word says whether the next item is a one-byte literal or a two-byte copy item.

For every data byte the block emits a registered mode tag, the byte itself, and a five-byte history of the most recent data bytes. Control and header bytes never enter the history or the output. Downstream hashing and copy logic therefore see one unbroken item stream across group boundaries. The block counts the output that the decoded items will produce. When the header size is reached, it stops accepting input until the next clear. A synchronous clear returns everything to the start state so that a fresh stream can begin.

Top module: `lz_stream_parser`

## Requirements
- R1: After reset or clear, out_valid is 0, out_mode is 0 (idle), hist is all zero and blk_done is 0.
- R2: The first 8 accepted bytes form the header and produce no output. Bytes 0..3 are the output size, least significant byte first. Bit 0 of byte 4 is 1 for a compressed block and 0 for a raw block. Bytes 5..7 are ignored.
- R3: The 2 control bytes that open each group produce no output and do not enter hist. The control word is the first control byte in bits 7:0 and the second in bits 15:8.
- R4: A control bit of 0 marks a literal item of one data byte. That byte is output with out_mode 1.
- R5: A control bit of 1 marks a copy item of two data bytes, output with out_mode 2 and then out_mode 3. The copy produces (first byte bits 3:0) + 3 output bytes.
- R6: Control bits are used from bit 0 upward, one per item. After 16 items, the next 2 accepted bytes are the next group's control word.
- R7: In a raw block, every byte after the header is output with out_mode 1, with no control decoding.
- R8: hist holds the last five data bytes, the newest in bits 7:0. It changes only on the cycle that a data byte is output.
- R9: When a completed item or raw byte brings the produced count to at least the header size, blk_done goes to 1 and in_ready goes to 0.
- R10: A header size of 0 sets blk_done right after the header.
- R11: in_ready is 0 while clear is high. A clear in mid-stream restarts header decoding.
- R12: Each output appears on the clock edge that accepts its byte, and out_valid is 0 on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous restart of the parser |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser accepts a byte |
| in_byte | input | 8 | Compressed stream byte |
| out_valid | output | 1 | A data byte is presented |
| out_mode | output | 2 | 0 idle, 1 literal, 2 copy first, 3 copy second |
| out_byte | output | 8 | The data byte |
| hist | output | 40 | Last five data bytes, newest in bits 7:0 |
| blk_size | output | 32 | Output size from the header |
| blk_compressed | output | 1 | Header compressed flag |
| blk_done | output | 1 | Declared output size reached |

## Verification
The parser is fed several patterns. A mixed pattern of literals and copies spans three groups, the last one short, which tests the ordering of control bits and the control word that is skipped between groups. An all-copy group ends exactly at a group edge, which shows that completion wins over fetching another control word. A short all-literal stream and a raw block separate the compressed path from the raw path. A zero-size header and a clear in mid-stream check the start and end conditions. In every pattern, the bench computes the expected mode, byte and five-byte history for each accepted byte from the generated items alone.

// File: rtl/lz_stream_parser.sv
module lz_stream_parser #(
  parameter int SIZE_W     = 32,
  parameter int HDR_BYTES  = 8,
  parameter int CTRL_BYTES = 2,
  parameter int HIST       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_byte,
  output logic                out_valid,
  output logic [1:0]          out_mode,
  output logic [7:0]          out_byte,
  output logic [8*HIST-1:0]   hist,
  output logic [SIZE_W-1:0]   blk_size,
  output logic                blk_compressed,
  output logic                blk_done
);
  localparam int ITEMS    = 8 * CTRL_BYTES;
  localparam int IDX_W    = $clog2(ITEMS);
  localparam int HC_W     = $clog2(HDR_BYTES);
  localparam int CC_W     = (CTRL_BYTES > 1) ? $clog2(CTRL_BYTES) : 1;
  localparam int SZ_BYTES = SIZE_W / 8;
  localparam int FLAG_IDX = SZ_BYTES;

  localparam logic [1:0] M_IDLE = 2'd0, M_LIT = 2'd1, M_CP1 = 2'd2, M_CP2 = 2'd3;

  typedef enum logic [2:0] {ST_HDR, ST_CW, ST_DATA, ST_RAW, ST_DONE} st_t;

  st_t               st;
  logic [HC_W-1:0]   hdr_cnt;
  logic [CC_W-1:0]   cw_cnt;
  logic [ITEMS-1:0]  ctl;
  logic [IDX_W-1:0]  idx;
  logic              half;
  logic [SIZE_W-1:0] prod;
  logic              take;
  logic              dat_phase;
  logic [SIZE_W:0]   lit_sum, cpy_sum;

  assign in_ready  = !clear && (st != ST_DONE);
  assign take      = in_valid && in_ready;
  assign blk_done  = (st == ST_DONE);
  assign dat_phase = (st == ST_DATA) || (st == ST_RAW);
  assign lit_sum   = {1'b0, prod} + (SIZE_W+1)'(1);
  assign cpy_sum   = {1'b0, prod} + (SIZE_W+1)'(in_byte[3:0]) + (SIZE_W+1)'(3);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      st <= ST_HDR;
      hdr_cnt <= '0;
      cw_cnt <= '0;
      ctl <= '0;
      idx <= '0;
      half <= 1'b0;
      prod <= '0;
      out_valid <= 1'b0;
      out_mode <= M_IDLE;
      out_byte <= '0;
      hist <= '0;
      blk_size <= '0;
      blk_compressed <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_mode  <= M_IDLE;
      if (take) begin
        case (st)
          ST_HDR: begin
            if (int'(hdr_cnt) < SZ_BYTES) blk_size[8*hdr_cnt +: 8] <= in_byte;
            if (int'(hdr_cnt) == FLAG_IDX) blk_compressed <= in_byte[0];
            hdr_cnt <= hdr_cnt + 1'b1;
            if (int'(hdr_cnt) == HDR_BYTES-1) begin
              if (blk_size == '0) st <= ST_DONE;
              else if (blk_compressed) st <= ST_CW;
              else st <= ST_RAW;
            end
          end
          ST_CW: begin
            ctl[8*cw_cnt +: 8] <= in_byte;
            cw_cnt <= cw_cnt + 1'b1;
            if (int'(cw_cnt) == CTRL_BYTES-1) begin
              cw_cnt <= '0;
              idx <= '0;
              half <= 1'b0;
              st <= ST_DATA;
            end
          end
          ST_DATA: begin
            out_valid <= 1'b1;
            out_byte  <= in_byte;
            hist      <= {hist[8*HIST-9:0], in_byte};
            if (!half && ctl[0]) begin
              out_mode <= M_CP1;
              prod <= cpy_sum[SIZE_W-1:0];
              half <= 1'b1;
            end else begin
              out_mode <= half ? M_CP2 : M_LIT;
              half <= 1'b0;
              ctl  <= ctl >> 1;
              idx  <= idx + 1'b1;
              if (!half) prod <= lit_sum[SIZE_W-1:0];
              if ((half ? {1'b0, prod} : lit_sum) >= {1'b0, blk_size}) st <= ST_DONE;
              else if (int'(idx) == ITEMS-1) st <= ST_CW;
            end
          end
          ST_RAW: begin
            out_valid <= 1'b1;
            out_mode  <= M_LIT;
            out_byte  <= in_byte;
            hist      <= {hist[8*HIST-9:0], in_byte};
            prod      <= lit_sum[SIZE_W-1:0];
            if (lit_sum >= {1'b0, blk_size}) st <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module lz_stream_parser_chk #(
  parameter int HIST = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              in_valid,
  input logic              in_ready,
  input logic              dat_phase,
  input logic              out_valid,
  input logic [1:0]        out_mode,
  input logic [7:0]        out_byte,
  input logic [8*HIST-1:0] hist,
  input logic              blk_done
);
  a_r1_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!out_valid && hist == '0 && !blk_done));
  a_r3_nondata_silent: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (in_valid && in_ready && !dat_phase) |=> !out_valid);
  a_r5_copy_pair: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (out_valid && out_mode == 2'd2) |=> (!out_valid || out_mode == 2'd3));
  a_r8_hist_newest: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> hist[7:0] == out_byte);
  a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (!out_valid && !$past(clear)) |-> $stable(hist));
  a_r9_done_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> !in_ready);
  a_r12_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_mode == 2'd0);
endmodule

bind lz_stream_parser lz_stream_parser_chk #(.HIST(HIST)) u_chk (.*);

// File: tb/lz_stream_parser_bench.sv
module lz_stream_parser_bench;
  logic clk = 0, rst_n = 0, clear = 0, in_valid = 0;
  logic [7:0] in_byte = 0;
  logic in_ready, out_valid, blk_compressed, blk_done;
  logic [1:0] out_mode;
  logic [7:0] out_byte;
  logic [39:0] hist;
  logic [31:0] blk_size;

  lz_stream_parser u_lz_stream_parser (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] bbuf [0:511];
  logic [1:0] bmode [0:511];
  string      btag [0:511];
  int         blen, prod, k, grp;
  logic [39:0] mh;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp=0", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic [1:0] m, input string t);
    bbuf[blen] = b; bmode[blen] = m; btag[blen] = t; blen++;
  endtask

  task automatic add_group(input logic [15:0] cw, input int nitems);
    push(cw[7:0], 2'd0, "R3");
    push(cw[15:8], 2'd0, "R3");
    for (int i = 0; i < nitems; i++) begin
      k++;
      if (!cw[i]) begin
        push(8'h40 ^ 8'(k * 7), 2'd1, grp > 0 ? "R6" : "R4");
        prod += 1;
      end else begin
        push({4'(k) ^ 4'h9, 4'(k)}, 2'd2, grp > 0 ? "R6" : "R5");
        push(8'hC0 ^ 8'(k), 2'd3, grp > 0 ? "R6" : "R5");
        prod += (k % 16) + 3;
      end
    end
    grp++;
  endtask

  task automatic with_header(input int size, input bit comp);
    for (int i = blen - 1; i >= 0; i--) begin
      bbuf[i+8] = bbuf[i]; bmode[i+8] = bmode[i]; btag[i+8] = btag[i];
    end
    for (int i = 0; i < 8; i++) begin
      bmode[i] = 2'd0; btag[i] = "R2";
      bbuf[i] = (i < 4) ? 8'(size >> (8*i)) : (i == 4 ? {7'h55, comp} : 8'hEE);
    end
    blen += 8;
  endtask

  task automatic do_clear();
    @(negedge clk); in_valid = 0; clear = 1;
    #1 check(in_ready == 0, "R11", "ready during clear", in_ready, 0);
    @(posedge clk); #1;
    @(negedge clk); clear = 0;
    #1 check(!out_valid && out_mode == 0 && hist == 0 && !blk_done, "R1", "clear state",
             {out_valid, out_mode, blk_done}, 0);
    check(hist == 0, "R1", "hist cleared", hist, 0);
    mh = 0;
  endtask

  task automatic run(input int size, input bit comp, input int upto);
    for (int i = 0; i < upto; i++) begin
      @(negedge clk);
      check(in_ready == 1, btag[i], "ready for byte", in_ready, 1);
      in_valid = 1; in_byte = bbuf[i];
      @(posedge clk); #1;
      if (bmode[i] == 0) begin
        check(!out_valid, btag[i], "no output for non-data byte", out_valid, 0);
        check(hist == mh, btag[i], "hist held", hist, mh);
      end else begin
        mh = {mh[31:0], bbuf[i]};
        check(out_valid && out_mode == bmode[i], btag[i], "mode", {out_valid, out_mode}, {1'b1, bmode[i]});
        check(out_byte == bbuf[i], btag[i], "byte", out_byte, bbuf[i]);
        check(hist == mh, "R8", "history", hist, mh);
      end
      if (i == 7) begin
        check(blk_size == 32'(size), "R2", "size", blk_size, size);
        check(blk_compressed == comp, "R2", "flag", blk_compressed, comp);
      end
    end
    @(negedge clk); in_valid = 0;
  endtask

  task automatic done_check(input string req);
    #1 check(blk_done == 1 && in_ready == 0, req, "done and stalled", {blk_done, in_ready}, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check(!out_valid && out_mode == 0 && hist == 0 && !blk_done, "R1", "reset state",
             {out_valid, out_mode, blk_done}, 0);
    @(negedge clk); rst_n = 1;
    mh = 0;

    blen = 0; prod = 0; k = 0; grp = 0;
    add_group(16'hA5C3, 16); add_group(16'h0F31, 16); add_group(16'h001B, 5);
    with_header(prod, 1);
    run(prod, 1, blen);
    done_check("R9");

    do_clear();
    blen = 0; prod = 0; k = 100; grp = 0;
    add_group(16'hFFFF, 16);
    with_header(prod, 1);
    run(prod, 1, blen);
    done_check("R9");

    do_clear();
    blen = 0; prod = 0; k = 7; grp = 0;
    add_group(16'h0000, 3);
    with_header(prod, 1);
    run(prod, 1, blen);
    done_check("R9");

    do_clear();
    blen = 0;
    for (int i = 0; i < 20; i++) push(8'h11 * 8'(i) + 8'h3, 2'd1, "R7");
    with_header(20, 0);
    run(20, 0, blen);
    done_check("R9");

    do_clear();
    blen = 0;
    with_header(0, 1);
    run(0, 1, 8);
    done_check("R10");

    do_clear();
    blen = 0; prod = 0; k = 40; grp = 0;
    add_group(16'h5A5A, 16); add_group(16'h0003, 4);
    with_header(prod, 1);
    run(prod, 1, 20);
    do_clear();
    run(prod, 1, blen);
    done_check("R11");

    summary();
  end
endmodule